// File: doc/BRIEF.md
# Gated Serial-In Parallel-Out Shift Register

This block is an eight-stage shift register that takes one bit per rising clock edge and presents every stage at once on a parallel output bus. The incoming bit is the logical AND of two serial pins. Either pin can therefore act as an active-high qualifier for the other. With the qualifier low, zeros enter the register. With the qualifier high, the data pin passes through unchanged.

Each rising edge moves the contents one place, from stage 0 toward the last stage. The last stage is also brought out on its own pin so that a second register can be chained after it.

An active-low clear empties every stage at once. It does not wait for a clock edge. While it is held low, clock edges change nothing. Shifting resumes on the first rising edge after it is released.

Top module: `gated_sipo_reg`

## Requirements
- R1: The register has WIDTH stages (default 8) on `par_q`. Bit 0 is the stage that receives the serial bit. Bit WIDTH-1 is the oldest stage, so after eight edges bit 7 holds the first bit entered.
- R2: On each rising edge of `clk` with `clr_n` high, `par_q[0]` takes `ser_a & ser_b` as sampled at that edge.
- R3: With `ser_b` low, a zero enters regardless of `ser_a`. With `ser_b` high, the value of `ser_a` enters.
- R4: When `clr_n` goes low, `par_q` becomes all zeros at once, without any clock edge.
- R5: On each rising edge with `clr_n` high, `par_q[i]` takes the previous `par_q[i-1]` for every i from 1 to WIDTH-1.
- R6: Rising edges while `clr_n` is low leave `par_q` at zero. The first rising edge after `clr_n` returns high shifts normally.
- R7: `tail_q` always equals `par_q[WIDTH-1]`.
- R8: After a clear the output reads 8'h00. Eight edges with `ser_a` and `ser_b` both high then give 8'hFF.
- R9: `par_q` does not change on a falling edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| ser_a | input | 1 | Serial data pin, ANDed with ser_b |
| ser_b | input | 1 | Serial qualifier pin, ANDed with ser_a |
| par_q | output | WIDTH | Parallel view of all stages, bit 0 newest |
| tail_q | output | 1 | Last stage, for chaining a following register |

## Verification
The clear and the shift can meet within one clock period. The bench provokes this by dropping `clr_n` a few nanoseconds after a rising edge and checking for zeros before the next edge arrives. It also holds the clear across edges while both serial pins are high, which would otherwise shift ones in. Finally it releases the clear part-way through a period and expects exactly one new bit after the next edge. The checker keeps a flag that any clear pulse resets and each clean edge sets. The shift properties are judged only across periods that the flag shows were free of clear pulses, including short pulses that fall wholly between two edges.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    localparam int GSR_WIDTH_DEF = 8;

    // The two serial pins, bundled
    typedef struct packed {
        logic data;
        logic qual;
    } gsr_serial_t;

endpackage

// File: rtl/gsr_gate.sv
module gsr_gate
    import gsr_pkg::*;
(
    input  gsr_serial_t ser_i,
    output logic        bit_o
);

    // Qualifier high lets data through; low forces zero
    always_comb begin
        bit_o = ser_i.data & ser_i.qual;
    end

endmodule

// File: rtl/gsr_chain.sv
module gsr_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             in_bit,
    output logic [WIDTH-1:0] stages_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stg;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = in_bit;
        for (int i = 1; i < WIDTH; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages_o = st_q.stg;

endmodule

// File: rtl/gated_sipo_reg.sv
module gated_sipo_reg
    import gsr_pkg::*;
#(
    parameter int WIDTH = GSR_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ser_a,
    input  logic             ser_b,
    output logic [WIDTH-1:0] par_q,
    output logic             tail_q
);

    localparam int LAST = WIDTH - 1;

    gsr_serial_t ser_w;
    logic        gated_w;

    assign ser_w.data = ser_a;
    assign ser_w.qual = ser_b;

    gsr_gate u_gate (
        .ser_i (ser_w),
        .bit_o (gated_w)
    );

    gsr_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .clr_n    (clr_n),
        .in_bit   (gated_w),
        .stages_o (par_q)
    );

    assign tail_q = par_q[LAST];

endmodule

// File: rtl/gsr_checker.sv
module gsr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ser_a,
    input logic             ser_b,
    input logic [WIDTH-1:0] par_q
);

    // Set by each edge taken with clear high; any clear pulse resets it
    logic clean_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            clean_q <= 1'b0;
        end else begin
            clean_q <= 1'b1;
        end
    end

    assert_gated_entry_R2: assert property (@(posedge clk) disable iff (!clr_n)
        clean_q |-> par_q[0] == $past(ser_a & ser_b));

    assert_qual_low_zero_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (clean_q && !$past(ser_b)) |-> !par_q[0]);

    assert_stage_move_R5: assert property (@(posedge clk) disable iff (!clr_n)
        clean_q |-> par_q[WIDTH-1:1] == $past(par_q[WIDTH-2:0]));

    assert_clear_empty_R4: assert property (@(posedge clk)
        !clr_n |-> par_q == '0);

endmodule

bind gated_sipo_reg gsr_checker #(.WIDTH(WIDTH)) u_gsr_checker (
    .clk   (clk),
    .clr_n (clr_n),
    .ser_a (ser_a),
    .ser_b (ser_b),
    .par_q (par_q)
);

// File: tb/gated_sipo_reg_bench.sv
module gated_sipo_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk   = 1'b0;
    logic         clr_n = 1'b1;
    logic         ser_a = 1'b0;
    logic         ser_b = 1'b0;
    logic [W-1:0] par_q;
    logic         tail_q;

    logic [W-1:0] model = '0;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    gated_sipo_reg #(.WIDTH(W)) u_gated_sipo_reg (
        .clk    (clk),
        .clr_n  (clr_n),
        .ser_a  (ser_a),
        .ser_b  (ser_b),
        .par_q  (par_q),
        .tail_q (tail_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock period: check stability across the falling edge, drive,
    // then update the model at the rising edge and compare shortly after.
    task automatic step(input logic a, input logic b, input string req);
        @(negedge clk);
        #1;
        chk(par_q == model, "R9", par_q, model);
        ser_a = a;
        ser_b = b;
        @(posedge clk);
        if (clr_n) model = {model[W-2:0], a & b};
        else       model = '0;
        #2;
        chk(par_q == model, req, par_q, model);
        chk(tail_q == model[W-1], "R7", {7'b0, tail_q}, {7'b0, model[W-1]});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1 clr_n = 1'b0;
        #1;
        chk(par_q == 8'h00, "R8 reset", par_q, 8'h00);
        @(negedge clk);
        #1 clr_n = 1'b1;

        // R1 R2 R5: every byte shifted in with the qualifier high
        for (int v = 0; v < 256; v++) begin
            for (int k = W - 1; k >= 0; k--) begin
                step(v[k], 1'b1, "R5 shift");
            end
            chk(par_q == v[W-1:0], "R1 byte order", par_q, v[W-1:0]);
        end

        // R3: qualifier low forces zeros whatever ser_a does
        for (int k = 0; k < W; k++) step(1'b1, 1'b1, "R2");
        for (int k = 0; k < 2 * W; k++) step(k[0] ^ k[2], 1'b0, "R3 zero in");
        chk(par_q == 8'h00, "R3 drained", par_q, 8'h00);

        // R2 R3: all four pin combinations mixed over time
        for (int i = 0; i < 64; i++) step(i[0], i[1] ^ i[3], "R2 and");

        // R8: ones fill after clear
        clr_n = 1'b0;
        #1 clr_n = 1'b1;
        model = '0;
        chk(par_q == 8'h00, "R8 cleared", par_q, 8'h00);
        for (int k = 0; k < W; k++) step(1'b1, 1'b1, "R8 fill");
        chk(par_q == 8'hFF, "R8 full", par_q, 8'hFF);

        // R4: clear between edges takes effect without a clock
        clr_n = 1'b0;
        #1;
        model = '0;
        chk(par_q == 8'h00, "R4 async", par_q, 8'h00);
        // R6: edges while cleared change nothing
        step(1'b1, 1'b1, "R6 held");
        step(1'b1, 1'b1, "R6 held");
        #1 clr_n = 1'b1;
        step(1'b1, 1'b1, "R6 resume");
        chk(par_q == 8'h01, "R6 first bit", par_q, 8'h01);

        // R4: short pulse wholly between two edges, then normal shifting
        for (int k = 0; k < 5; k++) step(1'b1, 1'b1, "R5");
        clr_n = 1'b0;
        #2;
        chk(par_q == 8'h00, "R4 pulse", par_q, 8'h00);
        clr_n = 1'b1;
        model = '0;
        step(1'b1, 1'b1, "R6 after pulse");
        step(1'b0, 1'b1, "R5 after pulse");
        chk(par_q == 8'h02, "R5 pattern", par_q, 8'h02);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule